// File: doc/BRIEF.md
# Multi-Mode Plane Pixel Serializer

This block takes one display fetch made of four plane bytes (one byte per memory plane, 32 bits in all) and plays it out as eight 4-bit pixel values, one per dot clock. Three ways of pulling pixel bits out of the planes share one sequencer:
- **Bit-sliced:** every plane gives one bit to each pixel.
- **Pair-interleaved:** two bits at a time come from plane pairs.
- **Nibble:** four bits at a time come from a single plane.

The fetch logic pulses a load strobe with the plane bytes and the two mode bits. The serializer captures all of them. From the next clock it presents pixels with a valid flag. A new load may follow the last pixel with no gap, or may cut a running group short. Palette lookup and the joining of nibble pairs into 8-bit pixels happen downstream.

Top module: `plane_pixel_serializer`

## Requirements
- R1: After synchronous reset, `pix_valid_o` is 0 and `pix_o` is 0 until the first load.
- R2: A load in cycle t makes `pix_valid_o` 1 in cycles t+1 through t+8, showing pixels 0..7 in order. Without a new load, `pix_valid_o` then returns to 0 and `pix_o` reads 0 while invalid.
- R3: The mode is picked by fixed priority. `nibble_mode_i`=1 selects nibble mode whatever `pair_mode_i` is. Otherwise `pair_mode_i`=1 selects pair-interleaved mode. Otherwise bit-sliced mode is used. The mode is sampled only at load.
- R4: Bit-sliced mode: pixel i bit k equals bit (7-i) of plane k. Plane k sits at `planes_i[8k+7:8k]`.
- R5: Pair-interleaved mode: for pixels i=0..3, bits [1:0] are plane 0 bits [7-2i:6-2i] and bits [3:2] are plane 2 bits [7-2i:6-2i]. Pixels 4..7 do the same with plane 1 (low pair) and plane 3 (high pair), using j=i-4 in place of i.
- R6: Nibble mode: pixel 2m is the high nibble of plane m, and pixel 2m+1 is its low nibble (m=0..3).
- R7: A load while a group is still playing discards the rest of that group. Pixel 0 of the new group appears in the next cycle.
- R8: A load in the cycle that shows pixel 7 gives a continuous valid stream with no idle cycle between groups.
- R9: Plane bytes and mode bits presented without a load have no effect on the pixel stream or on the valid flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Capture a new fetch group |
| planes_i | input | 32 | Four plane bytes, plane k at bits [8k+7:8k] |
| nibble_mode_i | input | 1 | Nibble-per-plane grouping (highest priority) |
| pair_mode_i | input | 1 | Pair-interleaved grouping |
| pix_o | output | 4 | Current pixel value |
| pix_valid_o | output | 1 | Pixel output holds a valid value |

## Verification
The bench builds the block with its default sizes: four planes of eight bits, eight pixels per group and 4-bit pixels. At these sizes one group is short enough that every pixel position of every mode is compared. Back-to-back reloads, reloads cut in at every pixel offset, and loads with both mode bits set all occur within a few hundred cycles. A long run of random loads and random plane data then drives the group counter through its wrap and restart paths many times.

// File: rtl/pps_pkg.sv
package pps_pkg;

    localparam int PLANES      = 4;
    localparam int BYTE_W      = 8;
    localparam int PIX_W       = 4;
    localparam int PIX_PER_GRP = 8;
    localparam int IDX_W       = $clog2(PIX_PER_GRP);
    localparam int FETCH_W     = PLANES * BYTE_W;

    typedef enum logic [1:0] {
        MODE_SLICE  = 2'd0,
        MODE_PAIR   = 2'd1,
        MODE_NIBBLE = 2'd2
    } grp_mode_e;

    typedef struct packed {
        logic [PLANES-1:0][BYTE_W-1:0] bytes;
        grp_mode_e                     mode;
    } fetch_grp_t;

    // fixed priority: nibble grouping wins over pair grouping
    function automatic grp_mode_e pick_mode(input logic nib, input logic pair);
        if (nib)       return MODE_NIBBLE;
        else if (pair) return MODE_PAIR;
        else           return MODE_SLICE;
    endfunction

endpackage

// File: rtl/pps_group_reg.sv
module pps_group_reg
    import pps_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [PLANES-1:0][BYTE_W-1:0] bytes_in,
    input  grp_mode_e                     mode_in,
    output fetch_grp_t                    grp
);

    always_ff @(posedge clk) begin
        if (rst) begin
            grp.bytes <= '0;
            grp.mode  <= MODE_SLICE;
        end else if (load) begin
            grp.bytes <= bytes_in;
            grp.mode  <= mode_in;
        end
    end

endmodule

// File: rtl/pps_seq.sv
module pps_seq
    import pps_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [IDX_W-1:0] idx,
    output logic             active
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(PIX_PER_GRP - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            idx    <= '0;
        end else if (load) begin
            active <= 1'b1;
            idx    <= '0;
        end else if (active) begin
            if (idx == LAST_IDX) begin
                active <= 1'b0;
                idx    <= '0;
            end else begin
                idx <= idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/pps_pixel_mux.sv
module pps_pixel_mux
    import pps_pkg::*;
(
    input  fetch_grp_t       grp,
    input  logic [IDX_W-1:0] idx,
    output logic [PIX_W-1:0] pix
);

    logic [PIX_W-1:0]  slice_pix;
    logic [PIX_W-1:0]  pair_pix;
    logic [PIX_W-1:0]  nib_pix;
    logic [BYTE_W-1:0] lo_byte;
    logic [BYTE_W-1:0] hi_byte;
    logic [BYTE_W-1:0] nib_byte;
    logic [2:0]        pair_sh;

    // bit-sliced: one bit from each plane, MSB first
    for (genvar k = 0; k < PLANES; k++) begin : g_slice
        assign slice_pix[k] = grp.bytes[k][BYTE_W-1-int'(idx)];
    end

    // pair-interleaved: first half uses planes 0/2, second half planes 1/3
    always_comb begin
        lo_byte  = grp.bytes[{1'b0, idx[2]}];
        hi_byte  = grp.bytes[{1'b1, idx[2]}];
        pair_sh  = 3'd6 - {idx[1:0], 1'b0};
        pair_pix = {hi_byte[pair_sh +: 2], lo_byte[pair_sh +: 2]};
    end

    // nibble: two pixels per plane, high nibble first
    always_comb begin
        nib_byte = grp.bytes[idx[2:1]];
        nib_pix  = idx[0] ? nib_byte[3:0] : nib_byte[7:4];
    end

    always_comb begin
        unique case (grp.mode)
            MODE_PAIR:   pix = pair_pix;
            MODE_NIBBLE: pix = nib_pix;
            default:     pix = slice_pix;
        endcase
    end

endmodule

// File: rtl/plane_pixel_serializer.sv
module plane_pixel_serializer
    import pps_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load_i,
    input  logic [FETCH_W-1:0] planes_i,
    input  logic               nibble_mode_i,
    input  logic               pair_mode_i,
    output logic [PIX_W-1:0]   pix_o,
    output logic               pix_valid_o
);

    grp_mode_e        mode_sel;
    fetch_grp_t       grp;
    logic [IDX_W-1:0] idx;
    logic             active;
    logic [PIX_W-1:0] mux_pix;

    assign mode_sel = pick_mode(nibble_mode_i, pair_mode_i);

    pps_group_reg u_grp (
        .clk      (clk),
        .rst      (rst),
        .load     (load_i),
        .bytes_in (planes_i),
        .mode_in  (mode_sel),
        .grp      (grp)
    );

    pps_seq u_seq (
        .clk    (clk),
        .rst    (rst),
        .load   (load_i),
        .idx    (idx),
        .active (active)
    );

    pps_pixel_mux u_mux (
        .grp (grp),
        .idx (idx),
        .pix (mux_pix)
    );

    assign pix_o       = active ? mux_pix : '0;
    assign pix_valid_o = active;

endmodule

// File: rtl/pps_checker.sv
module pps_checker
    import pps_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               load_i,
    input logic [FETCH_W-1:0] planes_i,
    input logic               nibble_mode_i,
    input logic               pair_mode_i,
    input logic [PIX_W-1:0]   pix_o,
    input logic               pix_valid_o
);

    localparam int CNT_W = $clog2(PIX_PER_GRP + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(PIX_PER_GRP);

    logic [CNT_W-1:0] since_load;

    always_ff @(posedge clk) begin
        if (rst)                                           since_load <= '0;
        else if (load_i)                                   since_load <= CNT_W'(1);
        else if (since_load != '0 && since_load != CNT_END) since_load <= since_load + 1'b1;
        else                                               since_load <= '0;
    end

    p_valid_window_r2: assert property (@(posedge clk) disable iff (rst)
        pix_valid_o == (since_load != '0));

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (rst)
        !pix_valid_o |-> pix_o == '0);

    p_reload_r7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> pix_valid_o);

    p_nibble_first_r3: assert property (@(posedge clk) disable iff (rst)
        load_i && nibble_mode_i |=> pix_o == $past(planes_i[7:4]));

    p_pair_first_r5: assert property (@(posedge clk) disable iff (rst)
        load_i && !nibble_mode_i && pair_mode_i |=>
        pix_o == {$past(planes_i[23:22]), $past(planes_i[7:6])});

    p_slice_first_r4: assert property (@(posedge clk) disable iff (rst)
        load_i && !nibble_mode_i && !pair_mode_i |=>
        pix_o == {$past(planes_i[31]), $past(planes_i[23]), $past(planes_i[15]), $past(planes_i[7])});

endmodule

bind plane_pixel_serializer pps_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .load_i        (load_i),
    .planes_i      (planes_i),
    .nibble_mode_i (nibble_mode_i),
    .pair_mode_i   (pair_mode_i),
    .pix_o         (pix_o),
    .pix_valid_o   (pix_valid_o)
);

// File: tb/sim_plane_pixel_serializer.sv
module sim_plane_pixel_serializer;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load_i = 1'b0;
    logic [31:0] planes_i = '0;
    logic        nibble_mode_i = 1'b0;
    logic        pair_mode_i = 1'b0;
    logic [3:0]  pix_o;
    logic        pix_valid_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] exp_q[$];
    string      grp_tag = "R2";
    string      scen    = "R2";

    always #(CLK_PERIOD/2) clk = ~clk;

    plane_pixel_serializer u0 (
        .clk           (clk),
        .rst           (rst),
        .load_i        (load_i),
        .planes_i      (planes_i),
        .nibble_mode_i (nibble_mode_i),
        .pair_mode_i   (pair_mode_i),
        .pix_o         (pix_o),
        .pix_valid_o   (pix_valid_o)
    );

    function automatic logic [3:0] ref_pix(logic [31:0] p, int m, int i);
        logic [3:0] r;
        r = '0;
        if (m == 2) begin
            int pl;
            pl = i / 2;
            r = (i % 2 == 0) ? p[8*pl+4 +: 4] : p[8*pl +: 4];
        end else if (m == 1) begin
            int lo;
            int j;
            lo = (i < 4) ? 0 : 1;
            j  = i % 4;
            r[1:0] = {p[8*lo+7-2*j], p[8*lo+6-2*j]};
            r[3:2] = {p[8*(lo+2)+7-2*j], p[8*(lo+2)+6-2*j]};
        end else begin
            for (int k = 0; k < 4; k++) r[k] = p[8*k+7-i];
        end
        return r;
    endfunction

    task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: drive inputs, advance model, compare at the negedge
    task automatic step(logic ld, logic [31:0] p, logic nib, logic pr);
        int m;
        load_i = ld; planes_i = p; nibble_mode_i = nib; pair_mode_i = pr;
        @(posedge clk);
        @(negedge clk);
        if (ld) begin
            m = nib ? 2 : (pr ? 1 : 0);   // R3 priority
            grp_tag = (m == 2) ? "R6" : ((m == 1) ? "R5" : "R4");
            exp_q.delete();
            for (int i = 0; i < 8; i++) exp_q.push_back(ref_pix(p, m, i));
        end else if (exp_q.size() != 0) begin
            void'(exp_q.pop_front());
        end
        check({scen, "/R2 valid"}, {3'b0, pix_valid_o}, {3'b0, exp_q.size() != 0});
        if (exp_q.size() != 0) check({scen, "/", grp_tag, " pixel"}, pix_o, exp_q[0]);
        else                   check({scen, "/R2 idle pixel"}, pix_o, 4'h0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        @(negedge clk); @(negedge clk); @(negedge clk);
        check("R1 valid after reset", {3'b0, pix_valid_o}, 4'h0);
        check("R1 pixel after reset", pix_o, 4'h0);
        rst = 1'b0;

        scen = "R9";   // stimulus with no load must do nothing
        step(0, 32'hFFFF_FFFF, 1, 1);
        step(0, 32'h1234_5678, 0, 1);
        step(0, 32'hA5A5_A5A5, 1, 0);

        scen = "R4";
        step(1, 32'h8142_24C3, 0, 0);
        scen = "R9";   // inputs wiggle during the group
        for (int c = 0; c < 9; c++) step(0, 32'hDEAD_BEEF ^ c, c[0], c[1]);

        scen = "R5";
        step(1, 32'hC639_1BE4, 0, 1);
        for (int c = 0; c < 8; c++) step(0, 32'h0, 0, 0);

        scen = "R6";
        step(1, 32'h7654_3210, 0, 0);
        scen = "R6";
        step(1, 32'hFEDC_BA98, 1, 0);
        for (int c = 0; c < 8; c++) step(0, '0, 0, 0);

        scen = "R3";   // both bits set: nibble wins
        step(1, 32'h9C5A_E137, 1, 1);
        for (int c = 0; c < 8; c++) step(0, '0, 0, 0);

        scen = "R7";   // cut in at every offset
        for (int off = 0; off < 8; off++) begin
            step(1, 32'h1357_9BDF + off, 0, 1);
            for (int c = 0; c < off; c++) step(0, '0, 0, 0);
            step(1, 32'h2468_ACE0 ^ (off * 32'h0101_0101), off[0], 0);
        end
        for (int c = 0; c < 9; c++) step(0, '0, 0, 0);

        scen = "R8";   // seamless back-to-back
        for (int g = 0; g < 4; g++) begin
            step(1, 32'h0F1E_2D3C + g * 32'h1111_1111, g[1], g[0]);
            for (int c = 0; c < 7; c++) step(0, '0, 0, 0);
        end
        for (int c = 0; c < 9; c++) step(0, '0, 0, 0);

        scen = "R2";   // random traffic
        for (int c = 0; c < 3000; c++) begin
            logic ld;
            ld = (($urandom % 5) == 0);
            step(ld, $urandom, $urandom % 2, $urandom % 2);
        end
        for (int c = 0; c < 9; c++) step(0, '0, 0, 0);

        finish_run();
    end

endmodule